// File: doc/BRIEF.md
# Multi-Sector Disk Address Sequencer

This block walks a disk address through a transfer of several consecutive sectors. A load strobe captures six parameter bytes: physical head, logical cylinder (two bytes), logical head, logical sector and sector count. The block then raises a per-sector data request that carries the transfer length in bytes. It waits for a sector-done strobe from the data mover. Each strobe consumes one sector and moves the address on. The sector and head numbers wrap at programmable ending values, and the cylinder counts up when the head wraps.

The transfer stops after the last sector, or as soon as the error byte becomes nonzero. A cylinder rollover with sectors still left makes the error byte nonzero. When the transfer stops, the block pulses a done signal and presents seven result bytes on a valid/ready stream. While the transfer runs, it also gives the linear block address of the current sector, using the drive's heads-per-cylinder and sectors-per-track inputs. Moving the media data is left to the surrounding logic.

Top module: `disk_addr_seq`

## Requirements
- R1: A load strobe accepted while idle captures `load_bytes_i` as six bytes, most significant first, in this order: physical head, cylinder high, cylinder low, logical head, logical sector, sector count. The captured values appear on the address outputs in the next cycle, and the error byte reads 0.
- R2: While a transfer is waiting for a sector, `sect_req_o` is 1 and `xfer_len_o` equals `{len_hi_i, len_lo_i}`, a 12-bit byte count. Otherwise `sect_req_o` is 0 and `xfer_len_o` is 0.
- R3: Each accepted sector-done lowers the count by one. If the sector number equals `end_sector_i`, the sector number becomes 0 and the logical head advances. Otherwise the sector number increments.
- R4: If the logical head equals `end_track_i` when it advances, the head becomes 0 and the 16-bit cylinder increments, carrying from the low byte into the high byte (0x00FF becomes 0x0100).
- R5: Error bit 7 (end of cylinder) is set when the cylinder rolls over and the remaining count is nonzero. A rollover that consumes the last sector leaves bit 7 clear.
- R6: After a sector-done that leaves the count at zero or the error byte nonzero, no further sector is requested. `done_o` is 1 for exactly one cycle, in the cycle after that strobe.
- R7: `err_flags_i` bits 6..0 are ORed into error-byte bits 6..0 at each accepted sector-done. Bit 0 is missing address mark, 1 not writable, 2 no data, 3 not ready, 4 equipment check, 5 data error and 6 overrun.
- R8: `lba_o` equals ((cylinder × heads) + logical head) × sectors + sector, computed from the current address and the geometry inputs.
- R9: After done, the result stream gives seven bytes in this order: error byte, physical head, cylinder high, cylinder low, logical head, logical sector, remaining count. One byte is given per beat with valid and ready both high. A byte that is offered is held stable until it is accepted.
- R10: A load with a zero sector count finishes at once. `done_o` pulses in the next cycle, no sector is requested, and the results follow.
- R11: A load strobe while a transfer or result stream is active has no effect. A sector-done strobe when no sector is requested has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Parameter load strobe |
| load_bytes_i | input | 48 | Six parameter bytes, first byte in bits 47..40 |
| end_sector_i | input | 8 | Last sector number on a track |
| end_track_i | input | 8 | Last logical head number in a cylinder |
| len_hi_i | input | 4 | Upper 4 bits of the sector byte count |
| len_lo_i | input | 8 | Lower 8 bits of the sector byte count |
| geo_heads_i | input | 8 | Heads per cylinder, used for the LBA |
| geo_sectors_i | input | 8 | Sectors per track, used for the LBA |
| sector_done_i | input | 1 | Strobe: the current sector has been transferred |
| err_flags_i | input | 7 | Error bits 6..0 reported with sector-done |
| phys_head_o | output | 8 | Physical head |
| cyl_o | output | 16 | Logical cylinder |
| lhead_o | output | 8 | Logical head |
| lsect_o | output | 8 | Logical sector |
| count_o | output | 8 | Remaining sector count |
| lba_o | output | 32 | Linear block address of the current sector |
| sect_req_o | output | 1 | Sector data request |
| xfer_len_o | output | 12 | Byte count for the requested sector |
| done_o | output | 1 | One-cycle pulse when the transfer ends |
| err_o | output | 8 | Error byte |
| res_valid_o | output | 1 | Result byte valid |
| res_data_o | output | 8 | Result byte |
| res_ready_i | input | 1 | Result byte accepted |

## Verification
All results of a load or sector-done strobe appear in the cycle after the clock edge that samples it. This covers the address, count, error byte, LBA, request level and done pulse. The result byte is combinational from the current index, so it can be read as soon as valid is high. The bench changes inputs on falling edges and reads outputs on the next falling edge after the sampling edge, which is the first cycle in which each result is due. The done pulse is checked in that cycle and checked to be low one cycle later. During result streaming, ready is held low for one cycle on some bytes to confirm that the offered byte does not change.

// File: rtl/dseq_pkg.sv
package dseq_pkg;

  localparam int BYTE_W  = 8;
  localparam int CYL_W   = 16;
  localparam int N_PARAM = 6;
  localparam int N_RES   = 7;

  typedef struct packed {
    logic [BYTE_W-1:0] phead;
    logic [CYL_W-1:0]  cyl;
    logic [BYTE_W-1:0] lhead;
    logic [BYTE_W-1:0] lsect;
    logic [BYTE_W-1:0] cnt;
  } dseq_addr_t;

  typedef struct packed {
    dseq_addr_t a;
    logic       rolled;
  } dseq_step_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_RES  = 2'd2
  } dseq_state_t;

  // Move the address on by one sector.
  function automatic dseq_step_t dseq_advance(dseq_addr_t cur,
                                              logic [BYTE_W-1:0] esn,
                                              logic [BYTE_W-1:0] etn);
    dseq_step_t r;
    r        = '{a: cur, rolled: 1'b0};
    r.a.cnt  = cur.cnt - 1'b1;
    if (cur.lsect == esn) begin
      r.a.lsect = '0;
      if (cur.lhead == etn) begin
        r.a.lhead = '0;
        r.a.cyl   = cur.cyl + 1'b1;
        r.rolled  = 1'b1;
      end else begin
        r.a.lhead = cur.lhead + 1'b1;
      end
    end else begin
      r.a.lsect = cur.lsect + 1'b1;
    end
    return r;
  endfunction

endpackage

// File: rtl/dseq_addr.sv
module dseq_addr
  import dseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  dseq_addr_t        load_val_i,
  input  logic              adv_i,
  input  logic [6:0]        err_flags_i,
  input  logic [BYTE_W-1:0] end_sector_i,
  input  logic [BYTE_W-1:0] end_track_i,
  output dseq_addr_t        addr_o,
  output logic [BYTE_W-1:0] err_o,
  output logic              fin_o,
  output logic              rolled_o
);

  dseq_addr_t        addr_q;
  logic [BYTE_W-1:0] err_q;
  dseq_step_t        step;
  logic [BYTE_W-1:0] err_nxt;
  logic              enc_hit;

  always_comb begin
    step     = dseq_advance(addr_q, end_sector_i, end_track_i);
    enc_hit  = step.rolled && (step.a.cnt != '0);
    err_nxt  = err_q | {enc_hit, err_flags_i};
    fin_o    = (step.a.cnt == '0) || (err_nxt != '0);
    rolled_o = step.rolled;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      err_q  <= '0;
    end else if (load_i) begin
      addr_q <= load_val_i;
      err_q  <= '0;
    end else if (adv_i) begin
      addr_q <= step.a;
      err_q  <= err_nxt;
    end
  end

  assign addr_o = addr_q;
  assign err_o  = err_q;

  // R3
  cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !load_i) |=> addr_q.cnt == $past(addr_q.cnt) - 1'b1);

  // R3
  sect_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !load_i && addr_q.lsect == end_sector_i) |=> addr_q.lsect == '0);

  // R4
  cyl_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !load_i && rolled_o) |=>
      (addr_q.lhead == '0) && (addr_q.cyl == $past(addr_q.cyl) + 1'b1));

  // R5
  enc_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !load_i && !err_q[7]) |=>
      err_q[7] == ($past(rolled_o) && addr_q.cnt != '0));

endmodule

// File: rtl/dseq_lba.sv
module dseq_lba
  import dseq_pkg::*;
#(
  parameter int LBA_W = 32
)(
  input  logic [CYL_W-1:0]  cyl_i,
  input  logic [BYTE_W-1:0] head_i,
  input  logic [BYTE_W-1:0] sect_i,
  input  logic [BYTE_W-1:0] heads_i,
  input  logic [BYTE_W-1:0] sects_i,
  output logic [LBA_W-1:0]  lba_o
);

  function automatic logic [LBA_W-1:0] calc_lba(logic [CYL_W-1:0] c,
                                                logic [BYTE_W-1:0] h,
                                                logic [BYTE_W-1:0] s,
                                                logic [BYTE_W-1:0] nh,
                                                logic [BYTE_W-1:0] ns);
    logic [LBA_W-1:0] trk;
    trk = LBA_W'(c) * LBA_W'(nh) + LBA_W'(h);
    return trk * LBA_W'(ns) + LBA_W'(s);
  endfunction

  assign lba_o = calc_lba(cyl_i, head_i, sect_i, heads_i, sects_i);

endmodule

// File: rtl/dseq_result.sv
module dseq_result #(
  parameter int N = 7,
  parameter int W = 8
)(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         active_i,
  input  logic [N*W-1:0] bytes_i,
  input  logic         ready_i,
  output logic         valid_o,
  output logic [W-1:0] data_o,
  output logic         last_o
);

  localparam int IDX_W = $clog2(N);

  logic [W-1:0]     slot [N];
  logic [IDX_W-1:0] idx_q;
  logic             beat;

  for (genvar g = 0; g < N; g++) begin : g_slot
    assign slot[g] = bytes_i[(N-1-g)*W +: W];
  end

  assign valid_o = active_i;
  assign data_o  = slot[idx_q];
  assign beat    = active_i && ready_i;
  assign last_o  = beat && (idx_q == IDX_W'(N-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (last_o) idx_q <= '0;
    else if (beat)   idx_q <= idx_q + 1'b1;
  end

  // R9
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> valid_o && $stable(data_o));

endmodule

// File: rtl/disk_addr_seq.sv
module disk_addr_seq
  import dseq_pkg::*;
#(
  parameter int LEN_W = 12,
  parameter int LBA_W = 32
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [47:0]        load_bytes_i,
  input  logic [7:0]         end_sector_i,
  input  logic [7:0]         end_track_i,
  input  logic [LEN_W-9:0]   len_hi_i,
  input  logic [7:0]         len_lo_i,
  input  logic [7:0]         geo_heads_i,
  input  logic [7:0]         geo_sectors_i,
  input  logic               sector_done_i,
  input  logic [6:0]         err_flags_i,
  output logic [7:0]         phys_head_o,
  output logic [15:0]        cyl_o,
  output logic [7:0]         lhead_o,
  output logic [7:0]         lsect_o,
  output logic [7:0]         count_o,
  output logic [LBA_W-1:0]   lba_o,
  output logic               sect_req_o,
  output logic [LEN_W-1:0]   xfer_len_o,
  output logic               done_o,
  output logic [7:0]         err_o,
  output logic               res_valid_o,
  output logic [7:0]         res_data_o,
  input  logic               res_ready_i
);

  localparam int RES_BITS = N_RES * BYTE_W;

  dseq_state_t st_q, st_d;
  dseq_addr_t  addr, load_val;
  logic        load_acc, adv, fin, rolled, res_last, done_q;
  logic [RES_BITS-1:0] res_bytes;

  assign load_val = dseq_addr_t'(load_bytes_i);
  assign load_acc = load_i && (st_q == ST_IDLE);
  assign adv      = sector_done_i && (st_q == ST_XFER);

  dseq_addr u_addr (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_i       (load_acc),
    .load_val_i   (load_val),
    .adv_i        (adv),
    .err_flags_i  (err_flags_i),
    .end_sector_i (end_sector_i),
    .end_track_i  (end_track_i),
    .addr_o       (addr),
    .err_o        (err_o),
    .fin_o        (fin),
    .rolled_o     (rolled)
  );

  dseq_lba #(.LBA_W(LBA_W)) u_lba (
    .cyl_i   (addr.cyl),
    .head_i  (addr.lhead),
    .sect_i  (addr.lsect),
    .heads_i (geo_heads_i),
    .sects_i (geo_sectors_i),
    .lba_o   (lba_o)
  );

  assign res_bytes = {err_o, addr};

  dseq_result #(.N(N_RES), .W(BYTE_W)) u_res (
    .clk      (clk),
    .rst_n    (rst_n),
    .active_i (st_q == ST_RES),
    .bytes_i  (res_bytes),
    .ready_i  (res_ready_i),
    .valid_o  (res_valid_o),
    .data_o   (res_data_o),
    .last_o   (res_last)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (load_acc) st_d = (load_val.cnt == '0) ? ST_RES : ST_XFER;
      ST_XFER: if (adv && fin) st_d = ST_RES;
      ST_RES:  if (res_last) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= (st_q != ST_RES) && (st_d == ST_RES);
    end
  end

  assign phys_head_o = addr.phead;
  assign cyl_o       = addr.cyl;
  assign lhead_o     = addr.lhead;
  assign lsect_o     = addr.lsect;
  assign count_o     = addr.cnt;
  assign sect_req_o  = (st_q == ST_XFER);
  assign xfer_len_o  = sect_req_o ? {len_hi_i, len_lo_i} : '0;
  assign done_o      = done_q;

  // R6
  req_res_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sect_req_o && res_valid_o));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R6
  done_with_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> res_valid_o && !sect_req_o);

  // R10
  zero_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_acc && load_val.cnt == '0) |=> done_o && !sect_req_o);

  // R11
  busy_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && st_q != ST_IDLE && !adv) |=> $stable(addr) && $stable(err_o));

endmodule

// File: tb/test_disk_addr_seq.sv
module test_disk_addr_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_i = 1'b0;
  logic [47:0] load_bytes_i = '0;
  logic [7:0]  end_sector_i = 8'd3;
  logic [7:0]  end_track_i = 8'd1;
  logic [3:0]  len_hi_i = 4'h2;
  logic [7:0]  len_lo_i = 8'h00;
  logic [7:0]  geo_heads_i = 8'd2;
  logic [7:0]  geo_sectors_i = 8'd4;
  logic        sector_done_i = 1'b0;
  logic [6:0]  err_flags_i = '0;
  logic [7:0]  phys_head_o, lhead_o, lsect_o, count_o, err_o, res_data_o;
  logic [15:0] cyl_o;
  logic [31:0] lba_o;
  logic        sect_req_o, done_o, res_valid_o;
  logic [11:0] xfer_len_o;
  logic        res_ready_i = 1'b0;

  int checks = 0;
  int errors = 0;

  int e_ph, e_cyl, e_lh, e_ls, e_cnt, e_err;
  bit e_fin;

  always #5 clk = ~clk;

  disk_addr_seq i_disk_addr_seq (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .load_bytes_i(load_bytes_i),
    .end_sector_i(end_sector_i), .end_track_i(end_track_i),
    .len_hi_i(len_hi_i), .len_lo_i(len_lo_i),
    .geo_heads_i(geo_heads_i), .geo_sectors_i(geo_sectors_i),
    .sector_done_i(sector_done_i), .err_flags_i(err_flags_i),
    .phys_head_o(phys_head_o), .cyl_o(cyl_o), .lhead_o(lhead_o),
    .lsect_o(lsect_o), .count_o(count_o), .lba_o(lba_o),
    .sect_req_o(sect_req_o), .xfer_len_o(xfer_len_o), .done_o(done_o),
    .err_o(err_o), .res_valid_o(res_valid_o), .res_data_o(res_data_o),
    .res_ready_i(res_ready_i)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Model LBA written as track index then sector offset.
  function automatic longint model_lba();
    longint tracks;
    tracks = longint'(e_cyl) * longint'(geo_heads_i) + e_lh;
    return tracks * geo_sectors_i + e_ls;
  endfunction

  task automatic check_addr(input string req);
    chk({req, " phys head"}, phys_head_o, e_ph);
    chk({req, " cylinder"}, cyl_o, e_cyl);
    chk({req, " logical head"}, lhead_o, e_lh);
    chk({req, " sector"}, lsect_o, e_ls);
    chk({req, " count"}, count_o, e_cnt);
    chk({req, " error byte"}, err_o, e_err);
    chk("R8 lba", lba_o, model_lba());
  endtask

  task automatic do_load(input int ph, input int cyl, input int lh,
                         input int ls, input int cnt);
    load_bytes_i = {8'(ph), 16'(cyl), 8'(lh), 8'(ls), 8'(cnt)};
    load_i = 1'b1;
    tick();
    load_i = 1'b0;
    e_ph = ph; e_cyl = cyl; e_lh = lh; e_ls = ls; e_cnt = cnt; e_err = 0;
    e_fin = (cnt == 0);
  endtask

  task automatic do_sector(input int flags);
    err_flags_i = 7'(flags);
    sector_done_i = 1'b1;
    tick();
    sector_done_i = 1'b0;
    err_flags_i = '0;
    e_cnt = e_cnt - 1;
    if (e_ls != end_sector_i) e_ls++;
    else begin
      e_ls = 0;
      if (e_lh != end_track_i) e_lh++;
      else begin
        e_lh = 0;
        e_cyl = (e_cyl + 1) % 65536;
        if (e_cnt != 0) e_err = e_err | 8'h80;
      end
    end
    e_err = e_err | flags;
    e_fin = (e_cnt == 0) || (e_err != 0);
    check_addr("R3");
    chk("R6 request after sector", sect_req_o, !e_fin);
    chk("R6 done pulse", done_o, e_fin);
  endtask

  task automatic read_results(input bit stall);
    int exp_b [7];
    exp_b = '{e_err, e_ph, e_cyl >> 8, e_cyl & 255, e_lh, e_ls, e_cnt};
    for (int i = 0; i < 7; i++) begin
      if (stall && (i % 2 == 0)) begin
        res_ready_i = 1'b0;
        chk("R9 valid", res_valid_o, 1);
        chk("R9 byte", res_data_o, exp_b[i]);
        tick();
        chk("R9 held byte", res_data_o, exp_b[i]);
      end
      res_ready_i = 1'b1;
      chk("R9 valid", res_valid_o, 1);
      chk("R9 byte", res_data_o, exp_b[i]);
      tick();
    end
    res_ready_i = 1'b0;
    chk("R9 stream ends", res_valid_o, 0);
    chk("R2 idle no request", sect_req_o, 0);
  endtask

  task automatic t_reset();
    chk("R1 reset count", count_o, 0);
    chk("R1 reset error", err_o, 0);
    chk("R2 reset request", sect_req_o, 0);
    chk("R9 reset valid", res_valid_o, 0);
    chk("R6 reset done", done_o, 0);
  endtask

  task automatic t_basic();
    do_load(5, 16'h1234, 0, 1, 3);
    check_addr("R1");
    chk("R2 request", sect_req_o, 1);
    chk("R2 length", xfer_len_o, 12'h200);
    len_hi_i = 4'hA; len_lo_i = 8'h5C;
    #1 chk("R2 length change", xfer_len_o, 12'hA5C);
    do_sector(0);
    do_sector(0);
    do_sector(0);
    chk("R2 length idle", xfer_len_o, 0);
    tick();
    chk("R6 done one cycle", done_o, 0);
    read_results(1'b1);
  endtask

  task automatic t_cyl_carry();
    do_load(2, 16'h00FF, 1, 3, 2);
    check_addr("R1");
    do_sector(0);
    chk("R4 cylinder carry", cyl_o, 16'h0100);
    chk("R5 end of cylinder", err_o, 8'h80);
    read_results(1'b0);
  endtask

  task automatic t_wrap_last();
    do_load(1, 16'h0010, 1, 3, 1);
    do_sector(0);
    chk("R5 no flag on last", err_o, 0);
    chk("R4 cylinder", cyl_o, 16'h0011);
    read_results(1'b1);
  endtask

  task automatic t_err_flag();
    do_load(3, 16'h0200, 0, 0, 5);
    do_sector(0);
    do_sector(7'h20);
    chk("R7 data error bit", err_o, 8'h20);
    chk("R6 stop on error", count_o, 3);
    read_results(1'b0);
  endtask

  task automatic t_zero();
    do_load(4, 16'h0042, 1, 2, 0);
    chk("R10 no request", sect_req_o, 0);
    chk("R10 done", done_o, 1);
    chk("R10 results valid", res_valid_o, 1);
    check_addr("R10");
    read_results(1'b0);
  endtask

  task automatic t_ignore();
    do_load(6, 16'h0300, 0, 0, 2);
    load_bytes_i = {8'h11, 16'h7777, 8'h01, 8'h02, 8'h09};
    load_i = 1'b1;
    tick();
    load_i = 1'b0;
    check_addr("R11 load while busy");
    do_sector(0);
    do_sector(0);
    sector_done_i = 1'b1;
    tick();
    sector_done_i = 1'b0;
    check_addr("R11 sector-done while streaming");
    read_results(1'b0);
    sector_done_i = 1'b1;
    tick();
    sector_done_i = 1'b0;
    check_addr("R11 sector-done while idle");
    chk("R11 no done", done_o, 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    tick();
    t_basic();
    t_cyl_carry();
    t_wrap_last();
    t_err_flag();
    t_zero();
    t_ignore();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule